// File: doc/BRIEF.md
# PLL Frequency Slew Sequencer

This controller retunes a fractional-N PLL while it keeps running. A request gives a target integer multiplier, a fractional part and the VCO band the target lies in, together with the band the PLL is using now. The sequencer writes the divider registers through a simple register write port. When the bands match and the PLL is running, it then raises the update bit in the mode register. It waits for the PLL to clear that bit, holds off for a programmable settling time, and then polls lock detect before it reports completion. If the target band is different from the current one, the sequencer does not slew. It turns the PLL off, reprograms it and turns it back on.

A second request type brings the PLL up for the first time. It starts the PLL at the midpoint of its only allowed band, waits for lock, and then slews to the stored target. Every wait state has its own timeout, and a timeout raises an error flag. A request that arrives while a job is running is refused with a one-cycle reject pulse.

FSM states: `S_IDLE`, `S_WR_OFF`, `S_WR_L`, `S_WR_ALO`, `S_WR_AHI`, `S_WR_USER`, `S_WR_ON`, `S_UPD`, `S_WAIT_ACK`, `S_SETTLE`, `S_WAIT_LOCK`, `S_FINISH`. The transitions are as follows:

- **Start:** idle goes to `S_WR_L` on a calibration request or on a same-band slew, and to `S_WR_OFF` on a cross-band slew.
- **Divider writes:** `S_WR_L` is followed by `S_WR_ALO`, then by `S_WR_AHI`.
- **After the upper alpha word:** a reprogram, or the first calibration phase, goes to `S_WR_USER`. The second calibration phase, or a slew while the PLL is on, goes to `S_UPD`. A slew while the PLL is off goes to `S_FINISH`.
- **Re-enable path:** `S_WR_USER` goes to `S_WR_ON`, then to `S_SETTLE`.
- **Update handshake:** `S_UPD` goes to `S_WAIT_ACK`. That state goes to `S_SETTLE` on acknowledge and back to idle on timeout.
- **Settling:** `S_SETTLE` goes to `S_WAIT_LOCK` once the delay has run out.
- **Lock:** when lock is seen, `S_WAIT_LOCK` goes back to `S_WR_L` in the first calibration phase and to `S_FINISH` otherwise. On timeout it goes back to idle.
- **End:** `S_FINISH` goes to idle.

Top module: `pll_slew_seq`

## Requirements
- R1: On every job the divider registers are written in this sequence: integer value (address 1), then lower alpha word (address 2), then upper alpha word (address 3).
- R2: The alpha value is left-justified in a 64-bit field, shifted left by 64 minus the alpha width (24 by default). Address 2 gets bits 31:0 of that field and address 3 gets bits 63:32. The integer value is zero-extended into address 1.
- R3: A same-band slew with the PLL on writes 3 (enable bit 0 and update bit 1) to the mode register (address 0) after the upper alpha word. The sequencer then waits until the PLL's update-busy input goes low.
- R4: After the acknowledge, the sequencer spends ceil(SETTLE_NS/CLK_NS) cycles (100 by default) before it samples lock. Completion never comes earlier, even when lock is already high.
- R5: The done pulse comes only after lock detect has been seen high following the settle interval.
- R6: A same-band slew with the PLL off writes only the three divider registers and then pulses done, with no mode write.
- R7: A slew whose target band differs from the current band takes these steps: it writes 0 to mode, writes the three divider registers, writes the user register (address 4, with bit 0 as alpha enable and the band in the bits above it), writes 1 to mode, settles, waits for lock and pulses done. It never raises the update bit.
- R8: Calibration first writes the band midpoint ((BAND_MIN+BAND_MAX)/2 as an integer.fraction value), the user register and mode 1. It waits for lock, and then writes the target divider values followed by the update handshake, settle and lock.
- R9: If the acknowledge does not arrive within ACK_TMO cycles, or lock within LOCK_TMO cycles, the error output is set and the sequencer returns to idle without done. The error clears when the next request is accepted.
- R10: A request seen while busy produces a one-cycle reject pulse, and that request is never carried out.
- R11: After reset, busy, done, err, rej and the register write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slew_req | input | 1 | Start a retune to the target |
| cal_req | input | 1 | Start bring-up calibration, then retune to the target |
| tgt_l | input | L_W | Target integer multiplier |
| tgt_alpha | input | ALPHA_W | Target fractional value |
| tgt_band | input | BAND_W | VCO band of the target |
| cur_band | input | BAND_W | VCO band in use now |
| pll_on | input | 1 | PLL output is enabled |
| pll_upd_busy | input | 1 | Update bit readback; low means acknowledged |
| pll_lock | input | 1 | Lock detect |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register address (0 mode, 1 integer, 2 alpha low, 3 alpha high, 4 user) |
| reg_wdata | output | 32 | Register write data |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when a job completes |
| err | output | 1 | A wait timed out; held until the next accepted request |
| rej | output | 1 | One-cycle pulse when a request is refused |

## Verification
The assertions assume the PLL raises its update-busy readback on the same edge that the update write lands, and keeps it high until it acknowledges. They also assume `pll_on` changes only through the sequencer's own mode writes while a job is running. The bench's behavioural PLL stub follows these rules, and the bench changes the enable state only between jobs, while the sequencer is idle. Requests are driven for a single cycle away from the clock edge.

// File: rtl/pll_slew_pkg.sv
package pll_slew_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_OFF,
        S_WR_L,
        S_WR_ALO,
        S_WR_AHI,
        S_WR_USER,
        S_WR_ON,
        S_UPD,
        S_WAIT_ACK,
        S_SETTLE,
        S_WAIT_LOCK,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        J_SLEW,
        J_REPROG,
        J_CAL
    } job_t;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_L    = 3'd1;
    localparam logic [2:0] A_ALO  = 3'd2;
    localparam logic [2:0] A_AHI  = 3'd3;
    localparam logic [2:0] A_USER = 3'd4;

    localparam logic [31:0] MODE_OFF = 32'd0;
    localparam logic [31:0] MODE_RUN = 32'd1;
    localparam logic [31:0] MODE_UPD = 32'd3;

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pll_slew_wcnt.sv
module pll_slew_wcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pll_slew_fmt.sv
module pll_slew_fmt
    import pll_slew_pkg::*;
#(
    parameter int L_W         = 16,
    parameter int ALPHA_W     = 40,
    parameter int ALPHA_REG_W = 64,
    parameter int BAND_W      = 2
) (
    input  logic [2:0]         addr,
    input  logic [L_W-1:0]     l_val,
    input  logic [ALPHA_W-1:0] a_val,
    input  logic [BAND_W-1:0]  band,
    output logic [31:0]        word
);
    localparam int SH = ALPHA_REG_W - ALPHA_W;

    logic [ALPHA_REG_W-1:0] a_just;

    generate
        if (SH == 0) begin : g_noshift
            assign a_just = a_val;
        end else begin : g_shift
            assign a_just = {a_val, {SH{1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case (addr)
            A_L:     word = 32'(l_val);
            A_ALO:   word = a_just[31:0];
            A_AHI:   word = 32'(a_just >> 32);
            A_USER:  word = 32'({band, 1'b1});
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/pll_slew_seq.sv
module pll_slew_seq
    import pll_slew_pkg::*;
#(
    parameter int L_W         = 16,
    parameter int ALPHA_W     = 40,
    parameter int ALPHA_REG_W = 64,
    parameter int BAND_W      = 2,
    parameter int CLK_NS      = 10,
    parameter int SETTLE_NS   = 1000,
    parameter int ACK_TMO     = 64,
    parameter int LOCK_TMO    = 512,
    parameter logic [L_W+ALPHA_W-1:0] BAND_MIN = (L_W+ALPHA_W)'(40) << ALPHA_W,
    parameter logic [L_W+ALPHA_W-1:0] BAND_MAX = ((L_W+ALPHA_W)'(60) << ALPHA_W)
                                                 | ((L_W+ALPHA_W)'(1) << (ALPHA_W-1))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slew_req,
    input  logic               cal_req,
    input  logic [L_W-1:0]     tgt_l,
    input  logic [ALPHA_W-1:0] tgt_alpha,
    input  logic [BAND_W-1:0]  tgt_band,
    input  logic [BAND_W-1:0]  cur_band,
    input  logic               pll_on,
    input  logic               pll_upd_busy,
    input  logic               pll_lock,
    output logic               reg_we,
    output logic [2:0]         reg_addr,
    output logic [31:0]        reg_wdata,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               rej
);
    localparam int FW         = L_W + ALPHA_W;
    localparam int SETTLE_CYC = ceil_div(SETTLE_NS, CLK_NS);
    localparam int CNT_W      = $clog2(max3(SETTLE_CYC, ACK_TMO, LOCK_TMO) + 1) + 1;
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] ACK_LAST    = CNT_W'(ACK_TMO - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_TMO - 1);
    localparam logic [FW:0]      MID_SUM     = {1'b0, BAND_MIN} + {1'b0, BAND_MAX};
    localparam logic [FW-1:0]    MID         = MID_SUM[FW:1];

    seq_state_t state_q, state_d;
    job_t       job_q;
    logic       cal_ph_q;
    logic [L_W-1:0]     l_q;
    logic [ALPHA_W-1:0] a_q;
    logic [BAND_W-1:0]  band_q;
    logic [CNT_W-1:0]   wcnt;
    logic               accept;
    logic               tmo;
    logic               mid_phase;
    logic [L_W-1:0]     l_use;
    logic [ALPHA_W-1:0] a_use;
    logic [31:0]        fmt_word;

    assign accept    = (state_q == S_IDLE) && (slew_req || cal_req);
    assign mid_phase = (job_q == J_CAL) && !cal_ph_q;
    assign l_use     = mid_phase ? MID[FW-1:ALPHA_W] : l_q;
    assign a_use     = mid_phase ? MID[ALPHA_W-1:0]  : a_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        tmo     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cal_req)                                  state_d = S_WR_L;
                else if (slew_req && (tgt_band != cur_band))  state_d = S_WR_OFF;
                else if (slew_req)                            state_d = S_WR_L;
            end
            S_WR_OFF:  state_d = S_WR_L;
            S_WR_L:    state_d = S_WR_ALO;
            S_WR_ALO:  state_d = S_WR_AHI;
            S_WR_AHI: begin
                if (job_q == J_REPROG || mid_phase) state_d = S_WR_USER;
                else if (job_q == J_CAL)            state_d = S_UPD;
                else if (pll_on)                    state_d = S_UPD;
                else                                state_d = S_FINISH;
            end
            S_WR_USER: state_d = S_WR_ON;
            S_WR_ON:   state_d = S_SETTLE;
            S_UPD:     state_d = S_WAIT_ACK;
            S_WAIT_ACK: begin
                if (!pll_upd_busy) begin
                    state_d = S_SETTLE;
                end else if (wcnt >= ACK_LAST) begin
                    state_d = S_IDLE;
                    tmo     = 1'b1;
                end
            end
            S_SETTLE: begin
                if (wcnt >= SETTLE_LAST) state_d = S_WAIT_LOCK;
            end
            S_WAIT_LOCK: begin
                if (pll_lock) begin
                    state_d = mid_phase ? S_WR_L : S_FINISH;
                end else if (wcnt >= LOCK_LAST) begin
                    state_d = S_IDLE;
                    tmo     = 1'b1;
                end
            end
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and job context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            job_q    <= J_SLEW;
            cal_ph_q <= 1'b0;
            l_q      <= '0;
            a_q      <= '0;
            band_q   <= '0;
            err      <= 1'b0;
            rej      <= 1'b0;
        end else begin
            state_q <= state_d;
            rej     <= (slew_req || cal_req) && (state_q != S_IDLE);
            if (accept) begin
                l_q      <= tgt_l;
                a_q      <= tgt_alpha;
                band_q   <= tgt_band;
                cal_ph_q <= 1'b0;
                err      <= 1'b0;
                if (cal_req)                      job_q <= J_CAL;
                else if (tgt_band != cur_band)    job_q <= J_REPROG;
                else                              job_q <= J_SLEW;
            end else begin
                if (tmo) err <= 1'b1;
                if (state_q == S_WAIT_LOCK && state_d == S_WR_L) cal_ph_q <= 1'b1;
            end
        end
    end

    pll_slew_wcnt #(.W(CNT_W)) i_wcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (wcnt)
    );

    pll_slew_fmt #(
        .L_W         (L_W),
        .ALPHA_W     (ALPHA_W),
        .ALPHA_REG_W (ALPHA_REG_W),
        .BAND_W      (BAND_W)
    ) i_fmt (
        .addr  (reg_addr),
        .l_val (l_use),
        .a_val (a_use),
        .band  (band_q),
        .word  (fmt_word)
    );

    // output logic
    always_comb begin
        reg_we    = 1'b0;
        reg_addr  = A_MODE;
        reg_wdata = fmt_word;
        unique case (state_q)
            S_WR_OFF:  begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = MODE_OFF; end
            S_WR_L:    begin reg_we = 1'b1; reg_addr = A_L;    end
            S_WR_ALO:  begin reg_we = 1'b1; reg_addr = A_ALO;  end
            S_WR_AHI:  begin reg_we = 1'b1; reg_addr = A_AHI;  end
            S_WR_USER: begin reg_we = 1'b1; reg_addr = A_USER; end
            S_WR_ON:   begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = MODE_RUN; end
            S_UPD:     begin reg_we = 1'b1; reg_addr = A_MODE; reg_wdata = MODE_UPD; end
            default:   begin reg_we = 1'b0; end
        endcase
        busy = (state_q != S_IDLE);
        done = (state_q == S_FINISH);
    end

    // R1: alpha low word only right after the integer write, high word right after low
    a_r1_alo_after_l: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ALO) |-> $past(reg_we && reg_addr == A_L));
    a_r1_ahi_after_alo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_AHI) |-> $past(reg_we && reg_addr == A_ALO));

    // R3: an update request is written only while the PLL is running
    a_r3_upd_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_MODE && reg_wdata[1] && job_q == J_SLEW) |-> $past(pll_on));

    // R5: completion after a lock wait requires lock seen in that wait
    a_r5_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state_q) == S_WAIT_LOCK) |-> $past(pll_lock));

    // R9: error only rises out of a wait state
    a_r9_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(state_q) == S_WAIT_ACK || $past(state_q) == S_WAIT_LOCK));

    // R10: reject pulse only for a request made while busy, never two in a row from one
    a_r10_rej_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rej |-> $past(busy && (slew_req || cal_req)));

    // R11: done and write strobe never together with idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !reg_we));

endmodule

// File: tb/test_pll_slew_seq.sv
module test_pll_slew_seq;
    localparam int CLK_NS     = 10;
    localparam int L_W        = 16;
    localparam int ALPHA_W    = 40;
    localparam int BAND_W     = 2;
    localparam int SETTLE_CYC = 100;
    localparam int ACK_TMO    = 64;
    localparam int LOCK_TMO   = 512;
    localparam int WD_LIMIT   = 150000;
    localparam logic [55:0] BMIN = 56'd40 << 40;
    localparam logic [55:0] BMAX = (56'd60 << 40) | (56'd1 << 39);

    typedef struct packed {
        logic        cal;
        logic [15:0] l;
        logic [39:0] a;
        logic [1:0]  band;
        logic [1:0]  cur;
        logic        on;
        logic [3:0]  exp_n;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 16'd52,    40'h12_3456_789A, 2'd1, 2'd1, 1'b1, 4'd4},
        '{1'b0, 16'd45,    40'hFF_FFFF_FFFF, 2'd1, 2'd1, 1'b1, 4'd4},
        '{1'b0, 16'd47,    40'h00_0000_0000, 2'd1, 2'd1, 1'b0, 4'd3},
        '{1'b0, 16'd55,    40'h80_0000_0001, 2'd2, 2'd1, 1'b1, 4'd6},
        '{1'b1, 16'd58,    40'h00_0000_0003, 2'd1, 2'd1, 1'b0, 4'd9},
        '{1'b0, 16'hFFFF,  40'h00_0000_0001, 2'd3, 2'd3, 1'b1, 4'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slew_req = 1'b0, cal_req = 1'b0;
    logic [L_W-1:0] tgt_l = '0;
    logic [ALPHA_W-1:0] tgt_alpha = '0;
    logic [BAND_W-1:0] tgt_band = '0, cur_band = '0;
    logic pll_on, pll_upd_busy, pll_lock;
    logic reg_we, busy, done, err, rej;
    logic [2:0] reg_addr;
    logic [31:0] reg_wdata;

    // stub controls
    logic tb_set_on = 1'b0, tb_on_val = 1'b0, tb_clr_log = 1'b0;
    logic hold_ack = 1'b0, no_lock = 1'b0;
    int   lock_dly = 5;
    int   cyc = 0;
    int   ack_cyc = 0;
    int   ack_cnt, lk_cnt;
    logic [2:0]  log_addr [16];
    logic [31:0] log_data [16];
    int   log_n;

    int checks = 0, errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    pll_slew_seq #(
        .CLK_NS(CLK_NS), .SETTLE_NS(1000), .ACK_TMO(ACK_TMO), .LOCK_TMO(LOCK_TMO),
        .BAND_MIN(BMIN), .BAND_MAX(BMAX)
    ) i_pll_slew_seq (
        .clk(clk), .rst_n(rst_n), .slew_req(slew_req), .cal_req(cal_req),
        .tgt_l(tgt_l), .tgt_alpha(tgt_alpha), .tgt_band(tgt_band), .cur_band(cur_band),
        .pll_on(pll_on), .pll_upd_busy(pll_upd_busy), .pll_lock(pll_lock),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy), .done(done), .err(err), .rej(rej)
    );

    // behavioural PLL stub and write logger
    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (tb_clr_log) log_n <= 0;
        if (tb_set_on) begin
            pll_on       <= tb_on_val;
            pll_lock     <= tb_on_val;
            pll_upd_busy <= 1'b0;
            lk_cnt       <= 0;
        end else if (reg_we && reg_addr == 3'd0) begin
            pll_on   <= reg_wdata[0];
            pll_lock <= 1'b0;
            lk_cnt   <= 0;
            if (reg_wdata[1]) begin
                pll_upd_busy <= 1'b1;
                ack_cnt      <= 0;
            end
        end else begin
            if (pll_upd_busy && !hold_ack) begin
                ack_cnt <= ack_cnt + 1;
                if (ack_cnt == 2) begin
                    pll_upd_busy <= 1'b0;
                    ack_cyc      <= cyc;
                end
            end
            if (pll_on && !pll_upd_busy && !no_lock && !pll_lock) begin
                lk_cnt <= lk_cnt + 1;
                if (lk_cnt >= lock_dly) pll_lock <= 1'b1;
            end
        end
        if (reg_we && !tb_clr_log) begin
            if (log_n < 16) begin
                log_addr[log_n] <= reg_addr;
                log_data[log_n] <= reg_wdata;
            end
            log_n <= log_n + 1;
        end
    end

    initial begin
        pll_on = 1'b0; pll_lock = 1'b0; pll_upd_busy = 1'b0;
        ack_cnt = 0; lk_cnt = 0; log_n = 0;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected write log
    logic [2:0]  e_addr [16];
    logic [31:0] e_data [16];
    int          e_n;

    task automatic push(input logic [2:0] a, input logic [31:0] d);
        e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    task automatic push_div(input logic [15:0] l, input logic [39:0] a);
        logic [63:0] aj;
        aj = {a, 24'h0};
        push(3'd1, {16'h0, l});
        push(3'd2, aj[31:0]);
        push(3'd3, aj[63:32]);
    endtask

    task automatic build_exp(input vec_t v);
        logic [56:0] sum;
        logic [55:0] mid;
        e_n = 0;
        if (v.cal) begin
            sum = {1'b0, BMIN} + {1'b0, BMAX};
            mid = sum[56:1];
            push_div(mid[55:40], mid[39:0]);
            push(3'd4, {29'h0, v.band, 1'b1});
            push(3'd0, 32'd1);
            push_div(v.l, v.a);
            push(3'd0, 32'd3);
        end else if (v.band != v.cur) begin
            push(3'd0, 32'd0);
            push_div(v.l, v.a);
            push(3'd4, {29'h0, v.band, 1'b1});
            push(3'd0, 32'd1);
        end else begin
            push_div(v.l, v.a);
            if (v.on) push(3'd0, 32'd3);
        end
    endtask

    int done_cyc;
    bit saw_done, saw_err;

    task automatic start_job(input vec_t v);
        @(negedge clk);
        tb_set_on = 1'b1; tb_on_val = v.on; tb_clr_log = 1'b1;
        @(negedge clk);
        tb_set_on = 1'b0; tb_clr_log = 1'b0;
        tgt_l = v.l; tgt_alpha = v.a; tgt_band = v.band; cur_band = v.cur;
        slew_req = !v.cal; cal_req = v.cal;
        @(negedge clk);
        slew_req = 1'b0; cal_req = 1'b0;
    endtask

    task automatic wait_end();
        saw_done = 0; saw_err = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin saw_done = 1; done_cyc = cyc; end
            if (!busy) begin saw_err = err; break; end
            @(negedge clk);
        end
    endtask

    task automatic compare_log(input string req);
        bit ok;
        int bad;
        ok = (log_n == e_n);
        bad = -1;
        for (int k = 0; k < e_n && k < 16; k++)
            if (ok && (log_addr[k] != e_addr[k] || log_data[k] != e_data[k])) begin
                ok = 0; bad = k;
            end
        if (bad >= 0)
            check(0, req, $sformatf("write %0d addr/data", bad),
                  {29'h0, log_addr[bad], log_data[bad]}, {29'h0, e_addr[bad], e_data[bad]});
        else
            check(ok, req, "write count", log_n, e_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !err && !rej && !reg_we, "R11", "outputs in reset",
              {busy, done, err, rej, reg_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !reg_we, "R11", "outputs after reset",
              {busy, done, err, reg_we}, 0);

        // table of vectors: R1 R2 R3 R6 R7 R8
        foreach (VEC[i]) begin
            build_exp(VEC[i]);
            start_job(VEC[i]);
            wait_end();
            check(saw_done && !saw_err, "R5", $sformatf("vector %0d completes", i),
                  {saw_done, saw_err}, 2'b10);
            check(log_n == int'(VEC[i].exp_n), "R6_R7_R8",
                  $sformatf("vector %0d write count", i), log_n, VEC[i].exp_n);
            compare_log($sformatf("R1_R2_R3 vector %0d", i));
            if (e_data[e_n-1] == 32'd3 && e_addr[e_n-1] == 3'd0) begin
                // R4: settle interval counted from acknowledge
                check((done_cyc - ack_cyc) >= SETTLE_CYC && (done_cyc - ack_cyc) <= SETTLE_CYC + 5,
                      "R4", $sformatf("vector %0d ack-to-done cycles", i),
                      done_cyc - ack_cyc, SETTLE_CYC);
            end
        end

        // R5: lock arriving well after settle delays completion
        lock_dly = SETTLE_CYC + 40;
        build_exp(VEC[0]);
        start_job(VEC[0]);
        wait_end();
        check(saw_done && (done_cyc - ack_cyc) >= SETTLE_CYC + 40, "R5",
              "done waits for late lock", done_cyc - ack_cyc, SETTLE_CYC + 40);
        lock_dly = 5;

        // R9: acknowledge timeout
        hold_ack = 1'b1;
        start_job(VEC[0]);
        wait_end();
        check(!saw_done && saw_err, "R9", "ack timeout sets err without done",
              {saw_done, saw_err}, 2'b01);
        hold_ack = 1'b0;

        // R9: err clears on next accepted request
        start_job(VEC[2]);
        check(!err, "R9", "err cleared on accept", err, 0);
        wait_end();
        check(saw_done && !err, "R9", "job after timeout completes", {saw_done, err}, 2'b10);

        // R9: lock timeout
        no_lock = 1'b1;
        start_job(VEC[0]);
        wait_end();
        check(!saw_done && saw_err, "R9", "lock timeout sets err without done",
              {saw_done, saw_err}, 2'b01);
        no_lock = 1'b0;

        // R10: request while busy is refused and not executed
        build_exp(VEC[0]);
        start_job(VEC[0]);
        tgt_l = 16'h1234; slew_req = 1'b1;
        @(negedge clk);
        slew_req = 1'b0;
        check(rej, "R10", "reject pulse", rej, 1);
        @(negedge clk);
        check(!rej, "R10", "reject is one cycle", rej, 0);
        wait_end();
        check(saw_done, "R10", "first job still completes", saw_done, 1);
        compare_log("R10 second request not executed");
        repeat (3) @(negedge clk);
        check(!busy && log_n == e_n, "R10", "no further job started", log_n, e_n);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule